// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Interface

This block is the byte-wide host front end of a two-channel serial controller. Each channel has sixteen write registers and sixteen read registers. The host reaches them through one control port per channel by indirect addressing: it first writes a pointer into register 0, then reads or writes the register that pointer names. A separate data port per channel carries transmit bytes out and received bytes in.

The write register contents leave the block on a flat bus, so the neighbouring transmit, receive and interrupt logic can decode their fields. For each channel, the block also derives the number of input clocks per serial bit from the divisor registers and the clock-mode field. Channel index 0 is channel B and index 1 is channel A. The receive and transmit engines update the data-port status flags through single-cycle pulses.

Top module: `sreg_host_if`

## Requirements
- R1: A control write made while the channel pointer is 0 loads the pointer from data bits 2:0. If data bits 5:3 equal 3'b001 (the point-high command), 8 is added to that pointer. Any other command value leaves the loaded pointer at bits 2:0.
- R2: A control write made while the pointer is nonzero, other than a reset command to register 9, stores the byte into the write register the pointer names. The pointer then returns to 0.
- R3: A control read returns the read register the pointer names, on host_rdata one cycle after the strobe, and clears the pointer to 0. Read registers other than 0, 1, 12 and 13 return 0.
- R4: Writes to write registers 12 and 13 are also copied into read registers 12 and 13. Let D be the 16-bit divisor formed by {WR13, WR12} and M be the factor selected by WR4 bits 7:6 (00→1, 01→16, 10→32, 11→64). The channel's bit_period field equals 2·(D+2)·M.
- R5: After reset, all write registers are 0 except WR4=0x04, WR9=0xC0, WR11=0x08, WR14=0x30 and WR15=0xF8. RR0 is 0x44, RR1 is 0x07, RR12 and RR13 are 0, and the pointer is 0.
- R6: Address bit ADDR_SHIFT selects control (0) or data (1). Address bit ADDR_SHIFT+1 selects the channel (0 is B, 1 is A). Each channel keeps its own pointer.
- R7: A data-port write sets RR0 bit 2 and RR1 bit 0. It raises tx_push for that channel, with the byte on tx_data, one cycle later, but only when WR5 bit 3 of that channel is 1.
- R8: A data-port read returns the channel's held receive byte and clears RR0 bit 0. A rx_load pulse captures its byte and sets RR0 bit 0 only while RR0 bit 0 is clear. Otherwise the pulse is dropped and the held byte is kept.
- R9: A control write to register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A and 11 resets both, to the R5 state. The writing channel's pointer returns to 0. With bits 7:6 = 00 the byte is stored in WR9.
- R10: A tx_start pulse clears RR0 bit 2 and RR1 bit 0 of its channel. A data write in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_addr | input | ADDR_SHIFT+2 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte, valid the cycle after host_rd |
| rx_load | input | 2 | Per-channel receive byte available pulse |
| rx_data | input | 16 | Receive bytes, channel index k at bits 8k+7:8k |
| tx_start | input | 2 | Per-channel pulse: transmitter has taken the buffered byte |
| tx_push | output | 2 | Per-channel pulse carrying a transmit byte |
| tx_data | output | 8 | Last byte written to a data port |
| wregs_flat | output | 256 | Write registers, channel k register r at bits 128k+8r+7:128k+8r |
| bit_period | output | 48 | Clocks per serial bit, channel k at bits 24k+23:24k |

## Verification
The assertions assume that the host never raises read and write in the same cycle. They also assume that a rx_load pulse does not coincide with a data read of the same channel, since that ordering is left undefined here. The bench keeps to these limits by changing its inputs only on falling edges and by running every host access through tasks that issue one strobe at a time. The engine pulses are kept in cycles of their own.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int NCH      = 2;
  localparam int NREG     = 16;
  localparam int PTR_W    = 4;
  localparam int DW       = 8;
  localparam int PERIOD_W = 24;

  localparam int REG_CLKMODE = 4;
  localparam int REG_TXCTL   = 5;
  localparam int REG_RESET   = 9;
  localparam int REG_DIVLO   = 12;
  localparam int REG_DIVHI   = 13;

  localparam logic [2:0] CMD_POINT_HIGH = 3'b001;
  localparam logic [7:0] RR0_INIT = 8'h44;
  localparam logic [7:0] RR1_INIT = 8'h07;

  // power-on contents of each write register
  function automatic logic [DW-1:0] wr_init(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  // pointer value produced by a write to register 0
  function automatic logic [PTR_W-1:0] next_ptr(input logic [DW-1:0] d);
    return {(d[5:3] == CMD_POINT_HIGH), d[2:0]};
  endfunction

  // input clocks per serial bit: 2*(div+2) times the mode factor
  function automatic logic [PERIOD_W-1:0] clocks_per_bit(input logic [15:0] div,
                                                         input logic [1:0]  mode);
    logic [PERIOD_W-1:0] base;
    base = ({8'd0, div} + 24'd2) << 1;
    case (mode)
      2'd0:    return base;
      2'd1:    return base << 4;
      2'd2:    return base << 5;
      default: return base << 6;
    endcase
  endfunction
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode #(
  parameter int ADDR_SHIFT = 0,
  localparam int ADDR_W = ADDR_SHIFT + 2
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [1:0]        wr_ctl,
  output logic [1:0]        wr_dat,
  output logic [1:0]        rd_ctl,
  output logic [1:0]        rd_dat,
  output logic              sel_data,
  output logic              sel_chan
);
  assign sel_data = host_addr[ADDR_SHIFT];
  assign sel_chan = host_addr[ADDR_SHIFT+1];

  for (genvar ch = 0; ch < 2; ch++) begin : g_strobe
    logic hit;
    assign hit        = (sel_chan == ch[0]);
    assign wr_ctl[ch] = host_wr && hit && !sel_data;
    assign wr_dat[ch] = host_wr && hit &&  sel_data;
    assign rd_ctl[ch] = host_rd && hit && !sel_data;
    assign rd_dat[ch] = host_rd && hit &&  sel_data;
  end
endmodule

// File: rtl/sreg_chan.sv
module sreg_chan
  import sreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctl,
  input  logic                wr_dat,
  input  logic                rd_ctl,
  input  logic                rd_dat,
  input  logic                soft_rst,
  input  logic [DW-1:0]       wdata,
  input  logic                rx_load,
  input  logic [DW-1:0]       rx_in,
  input  logic                tx_start,
  output logic [1:0]          rst_req,
  output logic [DW-1:0]       ctl_value,
  output logic [DW-1:0]       rx_byte,
  output logic                txen,
  output logic [NREG*DW-1:0]  wregs,
  output logic [PERIOD_W-1:0] bit_period
);
  logic [DW-1:0]    wr_q [NREG];
  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    rr0_q, rr1_q, rr12_q, rr13_q, rx_q;

  // named events for the checks below
  logic ptr_zero, reset_cmd, store_wr, rx_accept;
  assign ptr_zero  = (ptr_q == '0);
  assign reset_cmd = wr_ctl && (ptr_q == PTR_W'(REG_RESET)) && (wdata[7:6] != 2'b00);
  assign store_wr  = wr_ctl && !ptr_zero && !reset_cmd;
  assign rx_accept = rx_load && !rr0_q[0];
  assign rst_req   = reset_cmd ? wdata[7:6] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= wr_init(i);
      ptr_q  <= '0;
      rr0_q  <= RR0_INIT;
      rr1_q  <= RR1_INIT;
      rr12_q <= '0;
      rr13_q <= '0;
      rx_q   <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= wr_init(i);
      ptr_q  <= '0;
      rr0_q  <= RR0_INIT;
      rr1_q  <= RR1_INIT;
      rr12_q <= '0;
      rr13_q <= '0;
      rx_q   <= '0;
    end else begin
      if (wr_ctl) ptr_q <= ptr_zero ? next_ptr(wdata) : '0;
      if (rd_ctl) ptr_q <= '0;
      if (store_wr) begin
        wr_q[ptr_q] <= wdata;
        if (ptr_q == PTR_W'(REG_DIVLO)) rr12_q <= wdata;
        if (ptr_q == PTR_W'(REG_DIVHI)) rr13_q <= wdata;
      end
      if (tx_start) begin
        rr0_q[2] <= 1'b0;
        rr1_q[0] <= 1'b0;
      end
      if (wr_dat) begin
        rr0_q[2] <= 1'b1;
        rr1_q[0] <= 1'b1;
      end
      if (rd_dat) rr0_q[0] <= 1'b0;
      if (rx_accept) begin
        rr0_q[0] <= 1'b1;
        rx_q     <= rx_in;
      end
    end
  end

  always_comb begin
    case (ptr_q)
      4'd0:    ctl_value = rr0_q;
      4'd1:    ctl_value = rr1_q;
      4'd12:   ctl_value = rr12_q;
      4'd13:   ctl_value = rr13_q;
      default: ctl_value = '0;
    endcase
  end

  for (genvar r = 0; r < NREG; r++) begin : g_flat
    assign wregs[r*DW +: DW] = wr_q[r];
  end

  assign rx_byte    = rx_q;
  assign txen       = wr_q[REG_TXCTL][3];
  assign bit_period = clocks_per_bit({wr_q[REG_DIVHI], wr_q[REG_DIVLO]},
                                     wr_q[REG_CLKMODE][7:6]);

  p_ptr_clear_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |=> ptr_q == '0);
  p_ptr_clear_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !ptr_zero) |=> ptr_q == '0);
  p_soft_reset_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rr0_q == 8'h44 && rr1_q == 8'h07 && ptr_q == '0 && wr_q[9] == 8'hC0));
  p_divisor_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (store_wr && !soft_rst && ptr_q == 4'd12) |=> rr12_q == $past(wdata));
  p_txempty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !soft_rst) |=> (rr0_q[2] && rr1_q[0]));
  p_rxav_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && rr0_q[0] && !soft_rst) |=> !rr0_q[0]);
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rr0_q[0] && !soft_rst) |=> $stable(rx_q));
endmodule

// File: rtl/sreg_host_if.sv
module sreg_host_if
  import sreg_pkg::*;
#(
  parameter int ADDR_SHIFT = 0,
  localparam int ADDR_W = ADDR_SHIFT + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  input  logic [1:0]              rx_load,
  input  logic [15:0]             rx_data,
  input  logic [1:0]              tx_start,
  output logic [1:0]              tx_push,
  output logic [7:0]              tx_data,
  output logic [255:0]            wregs_flat,
  output logic [47:0]             bit_period
);
  logic [1:0] wr_ctl, wr_dat, rd_ctl, rd_dat, soft_rst, txen;
  logic       sel_data, sel_chan;
  logic [1:0] rst_req  [NCH];
  logic [7:0] ctl_val  [NCH];
  logic [7:0] rx_byte  [NCH];

  sreg_decode #(.ADDR_SHIFT(ADDR_SHIFT)) u_decode (
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .host_addr(host_addr),
    .wr_ctl   (wr_ctl),
    .wr_dat   (wr_dat),
    .rd_ctl   (rd_ctl),
    .rd_dat   (rd_dat),
    .sel_data (sel_data),
    .sel_chan (sel_chan)
  );

  // a reset command from either channel may target either channel
  assign soft_rst = rst_req[0] | rst_req[1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    sreg_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (wr_ctl[ch]),
      .wr_dat    (wr_dat[ch]),
      .rd_ctl    (rd_ctl[ch]),
      .rd_dat    (rd_dat[ch]),
      .soft_rst  (soft_rst[ch]),
      .wdata     (host_wdata),
      .rx_load   (rx_load[ch]),
      .rx_in     (rx_data[ch*8 +: 8]),
      .tx_start  (tx_start[ch]),
      .rst_req   (rst_req[ch]),
      .ctl_value (ctl_val[ch]),
      .rx_byte   (rx_byte[ch]),
      .txen      (txen[ch]),
      .wregs     (wregs_flat[ch*128 +: 128]),
      .bit_period(bit_period[ch*PERIOD_W +: PERIOD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      tx_push    <= '0;
      tx_data    <= '0;
    end else begin
      if (host_rd) host_rdata <= sel_data ? rx_byte[sel_chan] : ctl_val[sel_chan];
      tx_push <= wr_dat & txen;
      if (host_wr && sel_data) tx_data <= host_wdata;
    end
  end

  p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctl, wr_dat, rd_ctl, rd_dat}));
  p_txpush_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push[0] |-> $past(wr_dat[0]));
  p_reset_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst == 2'b11) |=> (wregs_flat[4*8 +: 8] == 8'h04 && wregs_flat[128 + 4*8 +: 8] == 8'h04));
endmodule

// File: tb/sreg_host_if_bench.sv
`timescale 1ns/1ps
module sreg_host_if_bench;
  localparam int SHIFT = 1;
  localparam int AW = SHIFT + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic [1:0]   rx_load = '0;
  logic [15:0]  rx_data = '0;
  logic [1:0]   tx_start = '0;
  logic [1:0]   tx_push;
  logic [7:0]   tx_data;
  logic [255:0] wregs_flat;
  logic [47:0]  bit_period;

  int checks = 0;
  int errors = 0;

  sreg_host_if #(.ADDR_SHIFT(SHIFT)) u_sreg_host_if (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_load(rx_load), .rx_data(rx_data), .tx_start(tx_start),
    .tx_push(tx_push), .tx_data(tx_data), .wregs_flat(wregs_flat),
    .bit_period(bit_period)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int ch, input int dat);
    return AW'(((ch << 1) | dat) << SHIFT);
  endfunction

  function automatic logic [7:0] init_wr(input int r);
    if (r == 4) return 8'h04;
    if (r == 9) return 8'hC0;
    if (r == 11) return 8'h08;
    if (r == 14) return 8'h30;
    if (r == 15) return 8'hF8;
    return 8'h00;
  endfunction

  function automatic logic [7:0] wr_of(input int ch, input int r);
    return wregs_flat[ch*128 + r*8 +: 8];
  endfunction

  task automatic hw(input int ch, input int dat, input logic [7:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_addr = mk(ch, dat); host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input int ch, input int dat, output logic [7:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = mk(ch, dat);
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic set_ptr(input int ch, input int r);
    if (r >= 8) hw(ch, 0, 8'h08 | 8'(r & 7));
    else if (r != 0) hw(ch, 0, 8'(r));
  endtask

  task automatic wr_reg(input int ch, input int r, input logic [7:0] v);
    set_ptr(ch, r);
    hw(ch, 0, v);
  endtask

  task automatic rd_reg(input int ch, input int r, output logic [7:0] v);
    set_ptr(ch, r);
    hr(ch, 0, v);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pulse_rx(input int ch, input logic [7:0] b);
    @(negedge clk);
    rx_load[ch] = 1'b1; rx_data[ch*8 +: 8] = b;
    @(negedge clk);
    rx_load = '0;
  endtask

  initial begin
    logic [7:0] v;
    logic [31:0] exp;
    do_reset();

    // R5 reset state through both interfaces
    for (int ch = 0; ch < 2; ch++) begin
      for (int r = 0; r < 16; r++) check("R5 wr init", 32'(wr_of(ch, r)), 32'(init_wr(r)));
      for (int r = 0; r < 16; r++) begin
        rd_reg(ch, r, v);
        exp = (r == 0) ? 32'h44 : (r == 1) ? 32'h07 : 32'h0;
        check("R5 R3 rr init", 32'(v), exp);
      end
    end

    // R2 R1 R6 sweep of all write registers except 9, both channels
    for (int ch = 0; ch < 2; ch++)
      for (int r = 1; r < 16; r++)
        if (r != 9) wr_reg(ch, r, 8'((r * 37 + ch * 91 + 5) & 255));
    for (int ch = 0; ch < 2; ch++)
      for (int r = 1; r < 16; r++)
        if (r != 9) check("R2 R6 stored", 32'(wr_of(ch, r)), 32'((r * 37 + ch * 91 + 5) & 255));
    // R4 mirror
    for (int ch = 0; ch < 2; ch++) begin
      rd_reg(ch, 12, v); check("R4 rr12 mirror", 32'(v), 32'((12 * 37 + ch * 91 + 5) & 255));
      rd_reg(ch, 13, v); check("R4 rr13 mirror", 32'(v), 32'((13 * 37 + ch * 91 + 5) & 255));
    end

    // R1 non-point-high command leaves pointer at bits 2:0
    do_reset();
    hw(1, 0, 8'h2D); hw(1, 0, 8'hA5);
    check("R1 other command", 32'(wr_of(1, 5)), 32'hA5);
    check("R1 no high offset", 32'(wr_of(1, 13)), 32'h00);
    // R3 pointer back at 0 after a read
    rd_reg(1, 1, v); hr(1, 0, v);
    check("R3 ptr cleared by read", 32'(v), 32'h44);

    // R4 bit period sweep
    for (int ch = 0; ch < 2; ch++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 4; k++) begin
          int d;
          d = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 16'h1234 : 16'hFFFF;
          wr_reg(ch, 12, 8'(d & 255));
          wr_reg(ch, 13, 8'(d >> 8));
          wr_reg(ch, 4, 8'((m << 6) | 4));
          exp = 32'(2 * (d + 2) * ((m == 0) ? 1 : (8 << m)));
          check("R4 bit period", 32'(bit_period[ch*24 +: 24]), exp);
        end

    // R9 reset codes
    do_reset();
    wr_reg(0, 3, 8'h11); wr_reg(1, 3, 8'h22);
    wr_reg(1, 9, 8'h40);
    check("R9 code01 resets B", 32'(wr_of(0, 3)), 32'h00);
    check("R9 code01 keeps A", 32'(wr_of(1, 3)), 32'h22);
    hr(1, 0, v); check("R9 writer ptr zero", 32'(v), 32'h44);
    wr_reg(0, 3, 8'h33);
    wr_reg(0, 9, 8'h80);
    check("R9 code10 resets A", 32'(wr_of(1, 3)), 32'h00);
    check("R9 code10 keeps B", 32'(wr_of(0, 3)), 32'h33);
    wr_reg(1, 3, 8'h44);
    wr_reg(1, 9, 8'hC0);
    check("R9 code11 B", 32'(wr_of(0, 3)), 32'h00);
    check("R9 code11 A", 32'(wr_of(1, 3)), 32'h00);
    wr_reg(0, 9, 8'h15);
    check("R9 code00 stores", 32'(wr_of(0, 9)), 32'h15);
    check("R9 code00 no reset", 32'(wr_of(0, 4)), 32'h04);

    // R10 R7 transmit flags and push
    do_reset();
    @(negedge clk); tx_start[1] = 1'b1; @(negedge clk); tx_start = '0;
    rd_reg(1, 0, v); check("R10 rr0 txe cleared", 32'(v), 32'h40);
    rd_reg(1, 1, v); check("R10 rr1 sent cleared", 32'(v), 32'h06);
    check("R10 other chan kept", 32'(wr_of(0, 4)), 32'h04);
    hw(1, 1, 8'h5C);
    check("R7 no push without enable", 32'(tx_push), 32'h0);
    rd_reg(1, 0, v); check("R7 rr0 txe set", 32'(v), 32'h44);
    rd_reg(1, 1, v); check("R7 rr1 sent set", 32'(v), 32'h07);
    wr_reg(1, 5, 8'h08);
    hw(1, 1, 8'hC3);
    check("R7 push", 32'(tx_push), 32'h2);
    check("R7 push data", 32'(tx_data), 32'hC3);
    @(negedge clk);
    check("R7 push single", 32'(tx_push), 32'h0);

    // R8 receive path
    pulse_rx(0, 8'h9E);
    rd_reg(0, 0, v); check("R8 rxav set", 32'(v), 32'h45);
    pulse_rx(0, 8'h17);
    hr(0, 1, v); check("R8 held byte", 32'(v), 32'h9E);
    rd_reg(0, 0, v); check("R8 rxav cleared", 32'(v), 32'h44);
    rd_reg(1, 0, v); check("R6 other channel rr0", 32'(v), 32'h44);
    pulse_rx(0, 8'h61);
    hr(0, 1, v); check("R8 next byte", 32'(v), 32'h61);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule